// File: doc/BRIEF.md
# Packet Transmit FIFO with Interrupt Flags

This block buffers outgoing packet bytes between a host and a bit-level framer. The host writes one byte per cycle, and each byte carries a flag that marks whether it closes a packet. The framer pops bytes in order. Each popped byte comes back one cycle later on a registered output, together with its end-of-packet flag. The block reports full, empty and a "ready" level. The ready level is high while the number of stored bytes is below a low-water mark, which the host picks from four levels through a 2-bit code.

Two events latch sticky interrupt flags:
- the ready level going from low to high;
- the buffer running dry while a packet is still open, meaning the last byte handed to the framer did not close its packet.

Each flag is cleared by writing 1 to its clear input, and each has its own enable. One active-high interrupt output combines the enabled flags. A host control bit resets the transmit path on its rising edge. That reset empties the buffer and cancels any pending underrun.

Top module: `pkt_tx_fifo`

## Requirements
- R1: Bytes leave in the order written. When a pop is accepted at a clock edge, `rd_valid` is high for the next cycle, with that byte on `rd_data` and its marker on `rd_eop`.
- R2: The buffer holds up to `DEPTH` (128) bytes. `full` is high exactly when 128 bytes are stored, and `empty` is high exactly when none are.
- R3: A write while `full` is high is discarded, and the discarded byte is never read out. A pop while `empty` is high leaves `rd_valid` low and changes nothing.
- R4: `ready` is high exactly when the stored count is below the low-water mark. `low_code` 0, 1, 2 and 3 select marks of 16, 32, 64 and 96 bytes. The output follows `low_code` within the same cycle.
- R5: `rdy_flag` sets on the clock edge after `ready` goes from 0 to 1. It does not set again while `ready` stays high.
- R6: `udr_flag` sets on the clock edge after the buffer becomes empty, when the last byte popped had `rd_eop` = 0. It sets once per such event and does not re-trigger while the buffer stays empty.
- R7: Running empty after popping a byte with `rd_eop` = 1 leaves `udr_flag` low.
- R8: A flag stays set until a cycle with its clear input high, and it reads 0 on the following edge. If a set event and a clear come in the same cycle, the flag stays set.
- R9: `irq` is high exactly when (`rdy_flag` and `rdy_irq_en`) or (`udr_flag` and `udr_irq_en`) holds.
- R10: A 0-to-1 change of `soft_rst` empties the buffer on the next edge and cancels a pending underrun. Keeping `soft_rst` high afterwards has no further effect, and writes are accepted during that time.
- R11: After `rst_n` goes low, the block shows `empty`=1, `full`=0, `ready`=1, `rd_valid`=0, both flags 0 and `irq`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 8 | Byte to store |
| wr_eop | input | 1 | Byte closes a packet |
| rd_en | input | 1 | Framer pop request |
| rd_data | output | 8 | Popped byte |
| rd_eop | output | 1 | Popped byte closes a packet |
| rd_valid | output | 1 | `rd_data`/`rd_eop` carry a popped byte |
| low_code | input | 2 | Low-water mark select |
| soft_rst | input | 1 | Transmit reset control bit, acts on the rising edge |
| full | output | 1 | Buffer full |
| empty | output | 1 | Buffer empty |
| ready | output | 1 | Count below low-water mark |
| rdy_irq_en | input | 1 | Enable for ready flag |
| udr_irq_en | input | 1 | Enable for underrun flag |
| rdy_irq_clr | input | 1 | Write-1 clear of ready flag |
| udr_irq_clr | input | 1 | Write-1 clear of underrun flag |
| rdy_flag | output | 1 | Sticky ready-rise flag |
| udr_flag | output | 1 | Sticky underrun flag |
| irq | output | 1 | Combined active-high interrupt |

## Verification
The assertions check these properties on every cycle:
- the count never exceeds 128 and `full` and `empty` are never high together;
- a refused write leaves the count unchanged;
- a refused pop produces no `rd_valid`;
- each flag rises only after its cause and holds until cleared;
- a control-bit edge empties the buffer.

Other behaviour depends on a particular history, so only the bench scenarios can show it:
- byte order and data integrity across a full fill and drain;
- the exact count at which each low-water code switches `ready`;
- the single firing of underrun per empty event;
- the cancellation of a pending underrun by the soft reset;
- set-over-clear priority.

// File: rtl/pkt_tx_pkg.sv
// Package pkt_tx_pkg
// Shared entry type and low-water mark computation for the packet
// transmit FIFO. Assumes byte-wide data.
package pkt_tx_pkg;

    localparam int unsigned BYTE_W = 8;

    // One stored element: the byte and its end-of-packet marker.
    typedef struct packed {
        logic              eop;
        logic [BYTE_W-1:0] data;
    } tx_entry_t;

    localparam int unsigned ENTRY_W = $bits(tx_entry_t);

    // Number of selectable low-water levels (2-bit code).
    localparam int unsigned N_MARKS = 4;

    // Low-water mark in bytes for a code, as a fraction of the depth:
    // 1/8, 1/4, 1/2, 3/4.
    function automatic int unsigned low_mark(input int unsigned code,
                                             input int unsigned depth);
        case (code)
            0:       return depth / 8;
            1:       return depth / 4;
            2:       return depth / 2;
            default: return (depth * 3) / 4;
        endcase
    endfunction

endpackage

// File: rtl/tx_byte_store.sv
// Module tx_byte_store
// Circular storage for FIFO entries. Push and pop arrive already
// qualified (never a push when full, never a pop when empty, never a
// pop together with clear). Popped entries are registered on the output.
// The head entry is also offered combinationally so that callers can
// inspect the marker of the entry being popped. DEPTH must be a power
// of two.
module tx_byte_store #(
    parameter int unsigned DEPTH = 128,
    parameter int unsigned W     = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         push,
    input  logic [W-1:0] push_entry,
    input  logic         pop,
    output logic [W-1:0] head_entry,
    output logic [W-1:0] out_entry,
    output logic         out_valid
);
    localparam int unsigned AW = $clog2(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;

    // Write the accepted entry into the array (no reset on storage).
    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr] <= push_entry;
        end
    end

    // Advance write and read pointers; a clear rewinds both.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr + 1'b1;
            if (pop)  rd_ptr <= rd_ptr + 1'b1;
        end
    end

    // Register the popped entry and its valid strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_entry <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= pop;
            if (pop) out_entry <= mem[rd_ptr];
        end
    end

    // Offer the entry at the read pointer without a clock delay.
    always_comb begin
        head_entry = mem[rd_ptr];
    end

    // R3
    // A cycle with no accepted pop must not produce a valid output.
    no_phantom_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pop |=> !out_valid);

endmodule

// File: rtl/tx_fill_status.sv
// Module tx_fill_status
// Keeps the stored-byte count and qualifies host writes and framer pops
// against it. Derives full, empty and the low-water ready level. The
// ready level compares the count with one of four marks chosen by
// low_code. Clear has priority over both requests.
module tx_fill_status #(
    parameter int unsigned DEPTH = 128
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       wr_req,
    input  logic       rd_req,
    input  logic [1:0] low_code,
    output logic       push,
    output logic       pop,
    output logic       full,
    output logic       empty,
    output logic       ready
);
    import pkt_tx_pkg::*;

    localparam int unsigned CW = $clog2(DEPTH + 1);

    logic [CW-1:0]      count;
    logic [N_MARKS-1:0] below;

    // Accept requests only when they can be honoured and no clear is active.
    always_comb begin
        push = wr_req && !full && !clear;
        pop  = rd_req && !empty && !clear;
    end

    // Track the number of stored bytes.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            count <= '0;
        end else begin
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // Compare the count with every selectable low-water mark.
    for (genvar m = 0; m < N_MARKS; m++) begin : g_mark
        localparam logic [CW-1:0] MARK = CW'(low_mark(m, DEPTH));
        always_comb begin
            below[m] = (count < MARK);
        end
    end

    // Level flags from the registered count.
    always_comb begin
        full  = (count == CW'(DEPTH));
        empty = (count == '0);
        ready = below[low_code];
    end

    // R2
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    // R2
    full_empty_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));

    // R3
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && full && !rd_req && !clear) |=> full);

endmodule

// File: rtl/tx_irq_sticky.sv
// Module tx_irq_sticky
// Detects the two interrupt events and holds them in sticky flags that
// the host clears by writing 1. The events are a rising ready level and
// the buffer running dry in the middle of a packet. An underrun is armed
// when a byte without end-of-packet is popped. It fires once when the
// buffer is empty and is cancelled by clear. A set event beats a
// clear in the same cycle.
module tx_irq_sticky (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic ready,
    input  logic empty,
    input  logic pop,
    input  logic head_eop,
    input  logic rdy_en,
    input  logic udr_en,
    input  logic rdy_clr,
    input  logic udr_clr,
    output logic rdy_flag,
    output logic udr_flag,
    output logic irq
);
    localparam int unsigned N_SRC = 2;
    localparam int unsigned SRC_RDY = 0;
    localparam int unsigned SRC_UDR = 1;

    logic             ready_q;
    logic             udr_armed;
    logic [N_SRC-1:0] event_v;
    logic [N_SRC-1:0] en_v;
    logic [N_SRC-1:0] clr_v;
    logic [N_SRC-1:0] flag_v;

    // Remember the previous ready level; reset matches the empty state.
    always_ff @(posedge clk) begin
        if (!rst_n) ready_q <= 1'b1;
        else        ready_q <= ready;
    end

    // Arm underrun on a mid-packet pop; disarm on fire, on EOP or on clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)      udr_armed <= 1'b0;
        else if (pop)             udr_armed <= !head_eop;
        else if (empty)           udr_armed <= 1'b0;
    end

    // Collect per-source event, enable and clear vectors.
    always_comb begin
        event_v[SRC_RDY] = ready && !ready_q;
        event_v[SRC_UDR] = empty && udr_armed;
        en_v[SRC_RDY]    = rdy_en;
        en_v[SRC_UDR]    = udr_en;
        clr_v[SRC_RDY]   = rdy_clr;
        clr_v[SRC_UDR]   = udr_clr;
    end

    // One sticky bit per source; set wins over write-1 clear.
    for (genvar s = 0; s < N_SRC; s++) begin : g_src
        always_ff @(posedge clk) begin
            if (!rst_n)          flag_v[s] <= 1'b0;
            else if (event_v[s]) flag_v[s] <= 1'b1;
            else if (clr_v[s])   flag_v[s] <= 1'b0;
        end
    end

    // Combine enabled flags into the interrupt line.
    always_comb begin
        rdy_flag = flag_v[SRC_RDY];
        udr_flag = flag_v[SRC_UDR];
        irq      = |(flag_v & en_v);
    end

    // R5
    rdy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rdy_flag) |-> $past(ready));

    // R6
    udr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(udr_flag) |-> $past(empty));

    // R8
    rdy_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy_flag && !rdy_clr) |=> rdy_flag);

    // R8
    udr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (udr_flag && !udr_clr) |=> udr_flag);

endmodule

// File: rtl/pkt_tx_fifo.sv
// Module pkt_tx_fifo
// Top of the packet transmit FIFO. Detects the rising edge of the
// soft-reset control bit and ties together the fill tracker, the entry
// storage and the sticky interrupt logic. Assumes the host and framer
// share one clock.
module pkt_tx_fifo #(
    parameter int unsigned DEPTH = 128
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       wr_eop,
    input  logic       rd_en,
    output logic [7:0] rd_data,
    output logic       rd_eop,
    output logic       rd_valid,
    input  logic [1:0] low_code,
    input  logic       soft_rst,
    output logic       full,
    output logic       empty,
    output logic       ready,
    input  logic       rdy_irq_en,
    input  logic       udr_irq_en,
    input  logic       rdy_irq_clr,
    input  logic       udr_irq_clr,
    output logic       rdy_flag,
    output logic       udr_flag,
    output logic       irq
);
    import pkt_tx_pkg::*;

    logic      soft_q;
    logic      soft_pulse;
    logic      push;
    logic      pop;
    tx_entry_t in_entry;
    tx_entry_t head_entry;
    tx_entry_t out_entry;

    // Sample the control bit to find its 0-to-1 transition.
    always_ff @(posedge clk) begin
        if (!rst_n) soft_q <= 1'b0;
        else        soft_q <= soft_rst;
    end

    // Form the clear pulse and the entry to store.
    always_comb begin
        soft_pulse    = soft_rst && !soft_q;
        in_entry.eop  = wr_eop;
        in_entry.data = wr_data;
    end

    tx_fill_status #(.DEPTH(DEPTH)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (soft_pulse),
        .wr_req   (wr_en),
        .rd_req   (rd_en),
        .low_code (low_code),
        .push     (push),
        .pop      (pop),
        .full     (full),
        .empty    (empty),
        .ready    (ready)
    );

    tx_byte_store #(.DEPTH(DEPTH), .W(ENTRY_W)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (soft_pulse),
        .push       (push),
        .push_entry (in_entry),
        .pop        (pop),
        .head_entry (head_entry),
        .out_entry  (out_entry),
        .out_valid  (rd_valid)
    );

    tx_irq_sticky u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (soft_pulse),
        .ready    (ready),
        .empty    (empty),
        .pop      (pop),
        .head_eop (head_entry.eop),
        .rdy_en   (rdy_irq_en),
        .udr_en   (udr_irq_en),
        .rdy_clr  (rdy_irq_clr),
        .udr_clr  (udr_irq_clr),
        .rdy_flag (rdy_flag),
        .udr_flag (udr_flag),
        .irq      (irq)
    );

    // Present the registered popped entry.
    always_comb begin
        rd_data = out_entry.data;
        rd_eop  = out_entry.eop;
    end

    // R10
    soft_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(soft_rst) |=> empty);

    // R9
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (rdy_flag || udr_flag));

endmodule

// File: tb/test_pkt_tx_fifo.sv
module test_pkt_tx_fifo;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       wr_eop = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic       rd_eop;
    logic       rd_valid;
    logic [1:0] low_code = 2'd3;
    logic       soft_rst = 1'b0;
    logic       full, empty, ready;
    logic       rdy_irq_en = 1'b0, udr_irq_en = 1'b0;
    logic       rdy_irq_clr = 1'b0, udr_irq_clr = 1'b0;
    logic       rdy_flag, udr_flag, irq;

    int tests = 0;
    int fails = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    pkt_tx_fifo i_pkt_tx_fifo (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .wr_eop(wr_eop), .rd_en(rd_en), .rd_data(rd_data), .rd_eop(rd_eop),
        .rd_valid(rd_valid), .low_code(low_code), .soft_rst(soft_rst),
        .full(full), .empty(empty), .ready(ready),
        .rdy_irq_en(rdy_irq_en), .udr_irq_en(udr_irq_en),
        .rdy_irq_clr(rdy_irq_clr), .udr_irq_clr(udr_irq_clr),
        .rdy_flag(rdy_flag), .udr_flag(udr_flag), .irq(irq)
    );

    // Vector: [20] wr, [19] rd, [18] eop, [17:10] data,
    //         [9] exp_valid, [8] exp_eop, [7:0] exp_data
    localparam int NVEC = 8;
    localparam logic [20:0] VEC [NVEC] = '{
        {3'b100, 8'hA1, 2'b00, 8'h00},
        {3'b101, 8'hB2, 2'b00, 8'h00},
        {3'b100, 8'hC3, 2'b00, 8'h00},
        {3'b010, 8'h00, 2'b10, 8'hA1},
        {3'b111, 8'hD4, 2'b11, 8'hB2},
        {3'b010, 8'h00, 2'b10, 8'hC3},
        {3'b010, 8'h00, 2'b11, 8'hD4},
        {3'b010, 8'h00, 2'b00, 8'h00}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic push(input logic [7:0] d, input logic e);
        wr_en = 1'b1; wr_data = d; wr_eop = e;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic pop1();
        rd_en = 1'b1;
        tick();
        rd_en = 1'b0;
    endtask

    function automatic int mark(input int code);
        case (code)
            0: return 16;
            1: return 32;
            2: return 64;
            default: return 96;
        endcase
    endfunction

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=<100000", cycles);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        tick();
        rst_n = 1'b1;
        // R11 reset state
        chk("R11 empty", empty, 1);
        chk("R11 full", full, 0);
        chk("R11 ready", ready, 1);
        chk("R11 rd_valid", rd_valid, 0);
        chk("R11 rdy_flag", rdy_flag, 0);
        chk("R11 udr_flag", udr_flag, 0);
        chk("R11 irq", irq, 0);

        // R1 order, R3 empty pop, R7 no underrun after EOP
        for (int v = 0; v < NVEC; v++) begin
            wr_en = VEC[v][20]; rd_en = VEC[v][19];
            wr_eop = VEC[v][18]; wr_data = VEC[v][17:10];
            tick();
            wr_en = 1'b0; rd_en = 1'b0;
            chk("R1 valid", rd_valid, VEC[v][9]);
            if (VEC[v][9]) begin
                chk("R1 data", rd_data, VEC[v][7:0]);
                chk("R1 eop", rd_eop, VEC[v][8]);
            end
        end
        chk("R3 empty after pops", empty, 1);
        tick();
        chk("R7 udr_flag", udr_flag, 0);
        chk("R5 rdy steady high", rdy_flag, 0);

        // R2/R4 fill to full with code 0
        low_code = 2'd0;
        for (int i = 0; i < 128; i++) begin
            push(i[7:0], i == 127);
            chk("R4 fill ready", ready, (i + 1) < 16);
            chk("R2 full", full, i == 127);
        end
        push(8'hEE, 1'b0); // R3 dropped write
        chk("R2 still full", full, 1);
        // R4 every code at every count, R1 data while draining
        for (int c = 128; c > 0; c--) begin
            for (int k = 0; k < 4; k++) begin
                low_code = k[1:0];
                #1;
                chk("R4 mark", ready, c < mark(k));
            end
            pop1();
            chk("R1 drain data", rd_data, 128 - c);
        end
        chk("R3 dropped write absent", empty, 1);
        chk("R7 eop end no udr", udr_flag, 0);

        // clear flags raised by code changes
        low_code = 2'd0;
        rdy_irq_clr = 1'b1; udr_irq_clr = 1'b1;
        tick();
        rdy_irq_clr = 1'b0; udr_irq_clr = 1'b0;
        tick(); tick();
        chk("R5 no set while high", rdy_flag, 0);

        // R5 rising edge timing
        for (int i = 0; i < 16; i++) push(8'h40 + i[7:0], 1'b0);
        chk("R4 ready low at 16", ready, 0);
        pop1();
        chk("R5 ready rose", ready, 1);
        chk("R5 flag not yet", rdy_flag, 0);
        tick();
        chk("R5 flag set", rdy_flag, 1);

        // R8 write-1 clear
        rdy_irq_clr = 1'b1;
        tick();
        rdy_irq_clr = 1'b0;
        chk("R8 cleared", rdy_flag, 0);
        // R8 set beats clear
        push(8'h50, 1'b0);
        chk("R4 ready low", ready, 0);
        pop1();
        rdy_irq_clr = 1'b1;
        tick();
        rdy_irq_clr = 1'b0;
        chk("R8 set wins", rdy_flag, 1);

        // R9 enables
        #1;
        chk("R9 no enable", irq, 0);
        rdy_irq_en = 1'b1; #1;
        chk("R9 rdy enabled", irq, 1);
        rdy_irq_en = 1'b0; udr_irq_en = 1'b1; #1;
        chk("R9 udr enabled no flag", irq, 0);

        // R6 underrun mid-packet
        for (int i = 0; i < 15; i++) pop1();
        chk("R6 empty", empty, 1);
        chk("R6 not yet", udr_flag, 0);
        tick();
        chk("R6 udr set", udr_flag, 1);
        chk("R9 irq from udr", irq, 1);
        udr_irq_clr = 1'b1;
        tick();
        udr_irq_clr = 1'b0;
        tick(); tick();
        chk("R6 once per event", udr_flag, 0);
        pop1();
        chk("R3 empty pop no valid", rd_valid, 0);
        tick();
        chk("R6 no retrigger on empty pop", udr_flag, 0);

        // R10 soft reset cancels pending underrun
        push(8'h61, 1'b0);
        push(8'h62, 1'b0);
        pop1();
        soft_rst = 1'b1;
        tick();
        chk("R10 emptied", empty, 1);
        tick(); tick();
        chk("R10 underrun cancelled", udr_flag, 0);
        push(8'h71, 1'b1);
        push(8'h72, 1'b1);
        chk("R10 held high no effect", empty, 0);
        soft_rst = 1'b0;
        pop1();
        chk("R10 first after reset", rd_data, 8'h71);
        pop1();
        chk("R10 second after reset", rd_data, 8'h72);
        chk("R10 empty after", empty, 1);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule